// File: doc/BRIEF.md
# Dual-Port RAM with Collision Busy Arbitration

This block is a synchronous memory with two identical, independent ports, called left and right. Each port has its own enable, write select, output enable, address, write data and registered read data. Either port can read or write any word in any cycle. The word count and the word width are parameters. The default depth is kept small so that elaboration stays light. Setting `ADDR_W` to 13 gives the full 8K-word array.

When both enabled ports present the same address, an arbiter grants the word to one port and raises busy on the other port. The winner is the port whose access to that address began first. A busy port cannot write. Its write is held off and takes effect at the first clock edge where busy is low, provided the port still requests it. Reads are never blocked.

A strap input selects master or slave mode. In master mode the arbiter drives the busy outputs. In slave mode the busy outputs stay low and write blocking follows busy inputs supplied from outside. This lets several devices share one master's decision when they are stacked side by side for a wider word.

Top module: `dpr_busy_ram`

## Requirements
- R1: After reset both read data outputs are zero and both busy outputs are low.
- R2: In master mode a busy output is high only while both ports are enabled and their addresses are equal. Busy is combinational, so it is visible in the same cycle as those inputs.
- R3: A port's access to an address begins in the first cycle it is enabled with that address. On a collision, the port whose access began in an earlier cycle wins, and the other port gets busy. The winner keeps the grant for as long as the match lasts. Busy drops in the first cycle the match ends.
- R4: If both ports begin an access to the same address in the same cycle, the left port wins and right busy goes high.
- R5: A write on a busy port leaves memory unchanged. The write commits at the first clock edge where that port's busy is low, if the port is still enabled with write select high.
- R6: Read data is registered. A port that is enabled with output enable high in one cycle shows the addressed word after the next edge. At an edge where the port is disabled or its output enable is low, read data becomes zero. A busy port still reads.
- R7: In slave mode (strap low) both busy outputs stay low and the internal decision is ignored. A port's write is blocked exactly while its busy input is 1.
- R8: When the winning port writes a word that the losing port is reading, the reader gets the old word at the edge of the write and the new word at the following edge.
- R9: A disabled port does no access and takes no part in arbitration. The other port never gets busy because of it.
- R10: The two ports behave identically. The right port wins when its access began earlier, and either port can write data that the other port then reads back.
- R11: If, in slave mode, both ports write the same address at the same edge with neither blocked, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the control and output registers |
| master_sel | input | 1 | 1 selects master mode (busy generated internally), 0 selects slave mode |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left port write select (1 writes) |
| l_oe | input | 1 | Left port output enable |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port registered read data |
| l_busy_in | input | 1 | Left port busy from an external master (slave mode only) |
| l_busy_out | output | 1 | Left port busy from the internal arbiter (master mode only) |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right port write select (1 writes) |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port registered read data |
| r_busy_in | input | 1 | Right port busy from an external master (slave mode only) |
| r_busy_out | output | 1 | Right port busy from the internal arbiter (master mode only) |

## Verification
The hardest situation to reach is a write that is held off by busy and then commits later. To set it up, the winning port first holds an address for a cycle with its output enable high, so that its access is plainly the earlier one. The other port then requests a write to the same word for several edges. Reading the word back through the winning port during that window shows the old data. Disabling the winner then releases busy, and a read on the next cycles shows the pending write landing. A second hard case is slave mode overriding the arbiter: the stimulus builds a collision that the internal logic would lose, clears that port's busy input, and shows the write landing anyway.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   // Which port currently holds a contested address
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

   localparam int PORT_LEFT  = 0;
   localparam int PORT_RIGHT = 1;
   localparam int NUM_PORTS  = 2;

endpackage

// File: rtl/dpr_port_track.sv
// Remembers whether a port was already enabled on the same address in the
// previous cycle, which marks its access as the older one.
module dpr_port_track #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic [ADDR_W-1:0] addr,
   output logic              hold
);

   logic              ce_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ce_q   <= 1'b0;
         addr_q <= '0;
      end else begin
         ce_q   <= ce;
         addr_q <= addr;
      end
   end

   assign hold = ce_q & ce & (addr_q == addr);

endmodule

// File: rtl/dpr_arbiter.sv
// Address-match contention logic with master/slave busy selection.
module dpr_arbiter
   import dpr_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter bit TIE_TO_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_sel,
   input  logic              l_ce,
   input  logic              r_ce,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              l_hold,
   input  logic              r_hold,
   input  logic              l_busy_in,
   input  logic              r_busy_in,
   output logic              l_block,
   output logic              r_block,
   output logic              l_busy_out,
   output logic              r_busy_out
);

   owner_e owner_q, owner_d;
   logic   match;
   logic   fresh_left;
   logic   win_left;
   logic   arb_l, arb_r;

   assign match = l_ce & r_ce & (l_addr == r_addr);

   // Decision for a collision with no prior owner
   generate
      if (TIE_TO_LEFT) begin : g_tie_left
         assign fresh_left = ~(r_hold & ~l_hold);
      end else begin : g_tie_right
         assign fresh_left = l_hold & ~r_hold;
      end
   endgenerate

   always_comb begin
      unique case (owner_q)
         OWN_LEFT:  win_left = 1'b1;
         OWN_RIGHT: win_left = 1'b0;
         default:   win_left = fresh_left;
      endcase
   end

   assign arb_l = match & ~win_left;
   assign arb_r = match &  win_left;

   always_comb begin
      if (!match)        owner_d = OWN_NONE;
      else if (win_left) owner_d = OWN_LEFT;
      else               owner_d = OWN_RIGHT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) owner_q <= OWN_NONE;
      else        owner_q <= owner_d;
   end

   assign l_block    = master_sel ? arb_l : l_busy_in;
   assign r_block    = master_sel ? arb_r : r_busy_in;
   assign l_busy_out = master_sel & arb_l;
   assign r_busy_out = master_sel & arb_r;

endmodule

// File: rtl/dpr_mem_core.sv
// Storage array with two write ports and two registered read ports.
module dpr_mem_core #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_wr,
   input  logic              r_wr,
   input  logic              l_rd,
   input  logic              r_rd,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic [DATA_W-1:0] r_rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // Right first so a same-word left write is the one kept
   always_ff @(posedge clk) begin
      if (r_wr) mem[r_addr] <= r_wdata;
      if (l_wr) mem[l_addr] <= l_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         l_rdata <= '0;
         r_rdata <= '0;
      end else begin
         l_rdata <= l_rd ? mem[l_addr] : '0;
         r_rdata <= r_rd ? mem[r_addr] : '0;
      end
   end

endmodule

// File: rtl/dpr_busy_ram.sv
module dpr_busy_ram
   import dpr_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter bit TIE_TO_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_sel,
   input  logic              l_ce,
   input  logic              l_we,
   input  logic              l_oe,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              l_busy_in,
   output logic              l_busy_out,
   input  logic              r_ce,
   input  logic              r_we,
   input  logic              r_oe,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   input  logic              r_busy_in,
   output logic              r_busy_out
);

   initial begin
      if (ADDR_W < 1 || ADDR_W > 16)
         $fatal(1, "dpr_busy_ram: ADDR_W must lie in 1..16");
      if (DATA_W < 1)
         $fatal(1, "dpr_busy_ram: DATA_W must be at least 1");
   end

   logic              ce_v   [NUM_PORTS];
   logic [ADDR_W-1:0] addr_v [NUM_PORTS];
   logic              hold_v [NUM_PORTS];

   assign ce_v[PORT_LEFT]    = l_ce;
   assign ce_v[PORT_RIGHT]   = r_ce;
   assign addr_v[PORT_LEFT]  = l_addr;
   assign addr_v[PORT_RIGHT] = r_addr;

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_trk
         dpr_port_track #(.ADDR_W(ADDR_W)) u_trk (
            .clk   (clk),
            .rst_n (rst_n),
            .ce    (ce_v[p]),
            .addr  (addr_v[p]),
            .hold  (hold_v[p])
         );
      end
   endgenerate

   logic l_block, r_block;

   dpr_arbiter #(.ADDR_W(ADDR_W), .TIE_TO_LEFT(TIE_TO_LEFT)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .master_sel (master_sel),
      .l_ce       (l_ce),
      .r_ce       (r_ce),
      .l_addr     (l_addr),
      .r_addr     (r_addr),
      .l_hold     (hold_v[PORT_LEFT]),
      .r_hold     (hold_v[PORT_RIGHT]),
      .l_busy_in  (l_busy_in),
      .r_busy_in  (r_busy_in),
      .l_block    (l_block),
      .r_block    (r_block),
      .l_busy_out (l_busy_out),
      .r_busy_out (r_busy_out)
   );

   logic l_wr, r_wr, l_rd, r_rd;

   assign l_wr = rst_n & l_ce & l_we & ~l_block;
   assign r_wr = rst_n & r_ce & r_we & ~r_block;
   assign l_rd = l_ce & l_oe;
   assign r_rd = r_ce & r_oe;

   dpr_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .l_wr    (l_wr),
      .r_wr    (r_wr),
      .l_rd    (l_rd),
      .r_rd    (r_rd),
      .l_addr  (l_addr),
      .r_addr  (r_addr),
      .l_wdata (l_wdata),
      .r_wdata (r_wdata),
      .l_rdata (l_rdata),
      .r_rdata (r_rdata)
   );

endmodule

// File: rtl/dpr_busy_ram_chk.sv
module dpr_busy_ram_chk #(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter bit TIE_TO_LEFT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              master_sel,
   input logic              l_ce,
   input logic              l_oe,
   input logic [ADDR_W-1:0] l_addr,
   input logic [DATA_W-1:0] l_rdata,
   input logic              l_busy_out,
   input logic              r_ce,
   input logic              r_oe,
   input logic [ADDR_W-1:0] r_addr,
   input logic [DATA_W-1:0] r_rdata,
   input logic              r_busy_out
);

   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R2
   busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_busy_out || r_busy_out) |-> (master_sel && l_ce && r_ce && l_addr == r_addr));

   // R3
   single_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_busy_out && r_busy_out));

   // R3
   left_grant_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && master_sel && $past(master_sel) && $past(r_busy_out) && l_ce && r_ce
       && l_addr == r_addr && $stable(l_addr) && $stable(r_addr)) |-> r_busy_out);

   // R10
   right_grant_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && master_sel && $past(master_sel) && $past(l_busy_out) && l_ce && r_ce
       && l_addr == r_addr && $stable(l_addr) && $stable(r_addr)) |-> l_busy_out);

   // R4
   tie_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && master_sel && l_ce && r_ce && l_addr == r_addr && !$past(l_ce) && !$past(r_ce))
      |-> (TIE_TO_LEFT ? (r_busy_out && !l_busy_out) : (l_busy_out && !r_busy_out)));

   // R7
   slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !master_sel |-> (!l_busy_out && !r_busy_out));

   // R6
   left_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(l_ce && l_oe)) |-> (l_rdata == '0));

   // R6
   right_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(r_ce && r_oe)) |-> (r_rdata == '0));

endmodule

bind dpr_busy_ram dpr_busy_ram_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIE_TO_LEFT(TIE_TO_LEFT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .master_sel (master_sel),
   .l_ce       (l_ce),
   .l_oe       (l_oe),
   .l_addr     (l_addr),
   .l_rdata    (l_rdata),
   .l_busy_out (l_busy_out),
   .r_ce       (r_ce),
   .r_oe       (r_oe),
   .r_addr     (r_addr),
   .r_rdata    (r_rdata),
   .r_busy_out (r_busy_out)
);

// File: tb/tb_dpr_busy_ram.sv
`timescale 1ns/1ps
module tb_dpr_busy_ram;

   localparam int AW = 10;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          master_sel = 1'b1;
   logic          l_ce = 0, l_we = 0, l_oe = 0, l_busy_in = 0;
   logic          r_ce = 0, r_we = 0, r_oe = 0, r_busy_in = 0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wdata = '0, r_wdata = '0;
   logic [DW-1:0] l_rdata, r_rdata;
   logic          l_busy_out, r_busy_out;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   dpr_busy_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
      .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
      .l_rdata(l_rdata), .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
      .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
      .r_rdata(r_rdata), .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
   );

   // {address, data}: even rows written by left and read by right, odd rows the reverse
   localparam logic [AW+DW-1:0] VEC [8] = '{
      {10'd1,   8'h5A}, {10'd2,   8'hC3}, {10'd1023, 8'hFF}, {10'd0,   8'h01},
      {10'd512, 8'h80}, {10'd77,  8'h00}, {10'd300,  8'h3C}, {10'd301, 8'hE7}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_l(input logic ce, input logic we, input logic oe,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      l_ce = ce; l_we = we; l_oe = oe; l_addr = a; l_wdata = d;
   endtask

   task automatic set_r(input logic ce, input logic we, input logic oe,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      r_ce = ce; r_we = we; r_oe = oe; r_addr = a; r_wdata = d;
   endtask

   task automatic idle();
      set_l(0, 0, 0, '0, '0);
      set_r(0, 0, 0, '0, '0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 l_rdata", l_rdata, 0);
      chk("R1 r_rdata", r_rdata, 0);
      chk("R1 busy", {l_busy_out, r_busy_out}, 0);

      // Table walk: R6 latency and R10 symmetry
      for (int i = 0; i < 8; i++) begin
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         {a, d} = VEC[i];
         if (i % 2 == 0) set_l(1, 1, 0, a, d); else set_r(1, 1, 0, a, d);
         tick();
         idle();
         if (i % 2 == 0) set_r(1, 0, 1, a, '0); else set_l(1, 0, 1, a, '0);
         tick();
         if (i % 2 == 0) chk("R6 right reads left write", r_rdata, d);
         else            chk("R10 left reads right write", l_rdata, d);
         idle();
      end
      tick();
      chk("R6 idle read zero", {l_rdata, r_rdata}, 0);

      // R2 different addresses, no busy
      set_l(1, 0, 1, 10'd5, '0);
      set_r(1, 0, 1, 10'd6, '0);
      #1 chk("R2 no busy on mismatch", {l_busy_out, r_busy_out}, 0);
      tick(); idle();

      // Preload words
      set_l(1, 1, 0, 10'd20, 8'h11); tick();
      set_l(1, 1, 0, 10'd60, 8'h10); tick();
      idle(); tick();

      // R3 / R5 left begins first, right write is held off
      set_l(1, 0, 1, 10'd20, '0); tick();
      set_r(1, 1, 0, 10'd20, 8'h77);
      #1 chk("R3 right busy", {l_busy_out, r_busy_out}, 2'b01);
      tick(); tick();
      chk("R5 blocked write leaves old data", l_rdata, 8'h11);
      l_ce = 0;
      #1 chk("R3 busy drops with match", r_busy_out, 0);
      tick();
      set_r(1, 0, 1, 10'd20, '0); tick();
      chk("R5 pending write commits", r_rdata, 8'h77);
      idle(); tick();

      // R10 right begins first, left loses
      set_r(1, 0, 1, 10'd21, '0); tick();
      set_l(1, 1, 0, 10'd21, 8'h66);
      #1 chk("R10 left busy", {l_busy_out, r_busy_out}, 2'b10);
      tick();
      r_ce = 0;
      #1 chk("R10 left busy released", l_busy_out, 0);
      tick();
      set_l(1, 0, 1, 10'd21, '0); tick();
      chk("R10 left write after release", l_rdata, 8'h66);
      idle(); tick();

      // R4 simultaneous start
      set_l(1, 0, 1, 10'd30, '0);
      set_r(1, 0, 1, 10'd30, '0);
      #1 chk("R4 tie goes left", {l_busy_out, r_busy_out}, 2'b01);
      tick(); idle(); tick();

      // R9 disabled port does not arbitrate
      set_l(0, 0, 0, 10'd40, '0);
      set_r(1, 1, 0, 10'd40, 8'h44);
      #1 chk("R9 no busy with disabled peer", r_busy_out, 0);
      tick();
      set_r(1, 0, 1, 10'd40, '0); tick();
      chk("R9 write landed", r_rdata, 8'h44);
      idle(); tick();

      // R8 winner writes while loser reads
      set_l(1, 1, 0, 10'd50, 8'hA5);
      set_r(1, 0, 1, 10'd50, '0);
      #1 chk("R8 reader busy", r_busy_out, 1);
      tick();
      l_ce = 0;
      tick();
      chk("R8 reader sees new data", r_rdata, 8'hA5);
      // R6 output enable low
      set_r(1, 0, 0, 10'd50, '0); tick();
      chk("R6 oe low gives zero", r_rdata, 0);
      idle(); tick();

      // R7 slave mode
      master_sel = 0;
      set_l(1, 1, 0, 10'd60, 8'h33); l_busy_in = 1;
      set_r(1, 0, 1, 10'd60, '0);
      #1 chk("R7 slave busy outputs low", {l_busy_out, r_busy_out}, 0);
      tick();
      set_l(1, 0, 1, 10'd60, '0); tick();
      chk("R7 busy_in blocks write", l_rdata, 8'h10);
      l_busy_in = 0;
      set_l(1, 1, 0, 10'd60, 8'h33); tick();
      set_l(1, 0, 1, 10'd60, '0); tick();
      chk("R7 write after busy_in clears", l_rdata, 8'h33);
      idle(); tick();
      // internal decision would block right; slave ignores it
      set_l(1, 0, 1, 10'd61, '0); tick();
      set_r(1, 1, 0, 10'd61, 8'h99); tick();
      set_r(1, 0, 1, 10'd61, '0); tick();
      chk("R7 internal arbitration ignored", r_rdata, 8'h99);
      idle(); tick();

      // R11 both write same word in slave mode
      set_l(1, 1, 0, 10'd70, 8'hAA);
      set_r(1, 1, 0, 10'd70, 8'h55);
      tick();
      idle();
      set_l(1, 0, 1, 10'd70, '0); tick();
      chk("R11 left data kept", l_rdata, 8'hAA);
      idle(); tick();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule